// File: doc/BRIEF.md
# Serial Register-Access Command Decoder

This block is the serial slave port of a larger device. A host controller frames each transaction by pulling an active-low select line low. The first byte the host shifts in is a command. When the command asks for register access, the block finishes a two-byte read or write against its own 64 x 8-bit register file. When the command names one of the two burst memories, the block raises a one-cycle strobe for that access type and leaves the data that follows to other logic.

While the command byte arrives, the block shifts out a status byte on the serial output. A two-bit selector field in one of its own registers chooses what that byte holds: a constant zero, or a snapshot of an external status bus.

The serial pins are sampled with the system clock through synchronisers. The serial clock must therefore run well below the system clock; eight system cycles per half period is enough. The transfer format is clock-idle-low. MOSI is sampled on the rising edge, MISO changes on the falling edge, and bits go most-significant first.

Top module: `spi_reg_decoder`

## Requirements
- R1: After reset every register reads 0x00, `miso` is 0 and all four mode strobes are low.
- R2: While the selector field (bits 1:0 of register 0x04) is 0, the byte shifted out during the command byte is 0x00.
- R3: While the selector field is 1, 2 or 3, the byte shifted out during the command byte equals `status_i` as sampled when select falls.
- R4: A command with bit 7 = 1 and bit 6 = 1 writes the second received byte into the register at address bits 5:0.
- R5: A command with bit 7 = 1 and bit 6 = 0 shifts out the addressed register during the second byte, and the MOSI data in that byte changes no register.
- R6: A command byte whose bits 7:5 are 001 pulses `fbuf_rd`, and one whose bits 7:5 are 011 pulses `fbuf_wr`.
- R7: A command byte whose bits 7:5 are 000 pulses `sram_rd`, and one whose bits 7:5 are 010 pulses `sram_wr`.
- R8: Each mode strobe is high for exactly one cycle per command, at most one strobe is high at a time, and bytes after such a command neither write registers nor raise strobes.
- R9: If select rises before a byte completes, no write takes place and the next transaction decodes its first byte as a new command.
- R10: Bytes after the second byte of a register access are ignored.
- R11: Bits are taken and returned MSB first; MOSI is sampled on rising SCLK edges and MISO changes only on falling SCLK edges or when select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| sel_n | input | 1 | Active-low transaction select |
| miso | output | 1 | Serial data to the host, 0 while not selected |
| status_i | input | 8 | Status word returned when the selector field is non-zero |
| reg_file_o | output | 512 | Register contents, register n at bits n*8+7 : n*8 |
| fbuf_rd | output | 1 | Frame-buffer read command strobe |
| fbuf_wr | output | 1 | Frame-buffer write command strobe |
| sram_rd | output | 1 | SRAM read command strobe |
| sram_wr | output | 1 | SRAM write command strobe |

## Verification
Some properties are checked by assertions on every cycle. At most one mode strobe is high, each strobe lasts a single cycle, the register file holds still while select is inactive, and the outgoing shift register moves only on a falling serial clock or a select start. Other behaviour needs the bench's scenarios. These cover command decoding, the status-byte choice, the values read and written, mid-byte aborts, and the discarding of surplus bytes. The bench compares what comes back on the serial line and the register outputs against values it computes itself.

// File: rtl/spi_reg_decoder.sv
module spi_reg_decoder #(
  parameter int ADDR_W   = 6,
  parameter int CFG_ADDR = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk,
  input  logic                          mosi,
  input  logic                          sel_n,
  output logic                          miso,
  input  logic [7:0]                    status_i,
  output logic [(8*(1<<ADDR_W))-1:0]    reg_file_o,
  output logic                          fbuf_rd,
  output logic                          fbuf_wr,
  output logic                          sram_rd,
  output logic                          sram_wr
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {PH_CMD, PH_RD, PH_WR, PH_SKIP} phase_t;

  logic [7:0]        regs [DEPTH];
  logic [2:0]        sclk_q, sel_q;
  logic [1:0]        mosi_q;
  logic [7:0]        rx_sh, tx_sh, rx_next;
  logic [2:0]        bit_cnt;
  logic [ADDR_W-1:0] addr;
  phase_t            phase;
  logic [3:0]        strb;
  logic              rise, fall, selected, sel_start;
  logic [7:0]        stat_byte;

  assign rise      = sclk_q[1] & ~sclk_q[2];
  assign fall      = ~sclk_q[1] & sclk_q[2];
  assign selected  = ~sel_q[1];
  assign sel_start = ~sel_q[1] & sel_q[2];
  assign rx_next   = {rx_sh[6:0], mosi_q[1]};
  assign stat_byte = (regs[CFG_ADDR][1:0] == 2'd0) ? 8'h00 : status_i;
  assign miso      = ~sel_n & tx_sh[7];
  assign {fbuf_wr, fbuf_rd, sram_wr, sram_rd} = strb;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign reg_file_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b000;
      sel_q  <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sel_q  <= {sel_q[1:0], sel_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= 8'h00;
      rx_sh   <= 8'h00;
      tx_sh   <= 8'h00;
      bit_cnt <= 3'd0;
      addr    <= '0;
      phase   <= PH_CMD;
      strb    <= 4'b0000;
    end else begin
      strb <= 4'b0000;
      if (!selected) begin
        bit_cnt <= 3'd0;
        phase   <= PH_CMD;
      end else begin
        if (sel_start) tx_sh <= stat_byte;
        if (rise) begin
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            case (phase)
              PH_CMD: begin
                if (rx_next[7]) begin
                  addr  <= rx_next[ADDR_W-1:0];
                  phase <= rx_next[6] ? PH_WR : PH_RD;
                end else begin
                  phase <= PH_SKIP;
                  case (rx_next[6:5])
                    2'b00:   strb <= 4'b0001;
                    2'b10:   strb <= 4'b0010;
                    2'b01:   strb <= 4'b0100;
                    default: strb <= 4'b1000;
                  endcase
                end
              end
              PH_WR: begin
                regs[addr] <= rx_next;
                phase      <= PH_SKIP;
              end
              PH_RD:   phase <= PH_SKIP;
              default: phase <= PH_SKIP;
            endcase
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) tx_sh <= (phase == PH_RD) ? regs[addr] : 8'h00;
          else                 tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fbuf_rd, fbuf_wr, sram_rd, sram_wr}));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (fbuf_rd | fbuf_wr | sram_rd | sram_wr) |=> !(fbuf_rd | fbuf_wr | sram_rd | sram_wr));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && $past(!selected)) |-> $stable(reg_file_o));

  a_r11_tx_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !sel_start) |=> $stable(tx_sh));

  a_r6_strobe_idle_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && $past(!selected)) |-> !(fbuf_rd | fbuf_wr | sram_rd | sram_wr));
endmodule

// File: tb/sim_spi_reg_decoder.sv
module sim_spi_reg_decoder;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0, mosi = 1'b0, sel_n = 1'b1;
  logic         miso;
  logic [7:0]   status_i = 8'h00;
  logic [511:0] reg_file_o;
  logic         fbuf_rd, fbuf_wr, sram_rd, sram_wr;

  int n_chk = 0, n_bad = 0;
  int c_frd = 0, c_fwr = 0, c_srd = 0, c_swr = 0;
  int cyc = 0;
  logic [7:0] tx [3];
  logic [7:0] rx [3];

  always #10 clk = ~clk;

  spi_reg_decoder u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .sel_n(sel_n),
    .miso(miso), .status_i(status_i), .reg_file_o(reg_file_o),
    .fbuf_rd(fbuf_rd), .fbuf_wr(fbuf_wr), .sram_rd(sram_rd), .sram_wr(sram_wr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fbuf_rd) c_frd <= c_frd + 1;
    if (fbuf_wr) c_fwr <= c_fwr + 1;
    if (sram_rd) c_srd <= c_srd + 1;
    if (sram_wr) c_swr <= c_swr + 1;
  end

  always @(posedge clk) if (cyc == 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int a);
    return reg_file_o[a*8 +: 8];
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int nbytes, input int nbits_last);
    sel_n = 1'b0;
    wait_clk(8);
    for (int b = 0; b < nbytes; b++) begin
      rx[b] = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        if (b == nbytes - 1 && (7 - i) >= nbits_last) break;
        mosi = tx[b][i];
        wait_clk(HALF);
        rx[b][i] = miso;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
      end
    end
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset;
    check("R1 reg0", rg(0), 8'h00);
    check("R1 reg63", rg(63), 8'h00);
    check("R1 miso", miso, 1'b0);
    check("R1 strobes", {fbuf_rd, fbuf_wr, sram_rd, sram_wr}, 4'h0);
  endtask

  task automatic t_write_read;
    status_i = 8'hA5;
    tx[0] = 8'hEA; tx[1] = 8'h85; xfer(2, 8);
    check("R4 write 0x2A", rg(42), 8'h85);
    check("R2 status zero", rx[0], 8'h00);
    tx[0] = 8'hFF; tx[1] = 8'h3C; xfer(2, 8);
    tx[0] = 8'hC0; tx[1] = 8'hC3; xfer(2, 8);
    check("R4 write 0x3F", rg(63), 8'h3C);
    check("R4 write 0x00", rg(0), 8'hC3);
    tx[0] = 8'hAA; tx[1] = 8'hFF; xfer(2, 8);
    check("R5 read data", rx[1], 8'h85);
    check("R5 mosi ignored", rg(42), 8'h85);
    tx[0] = 8'hBF; tx[1] = 8'h00; xfer(2, 8);
    check("R11 msb first", rx[1], 8'h3C);
  endtask

  task automatic t_status;
    tx[0] = 8'hC4; tx[1] = 8'h02; xfer(2, 8);
    status_i = 8'h5C;
    tx[0] = 8'h80; tx[1] = 8'h00; xfer(2, 8);
    check("R3 status byte", rx[0], 8'h5C);
    check("R5 read addr0", rx[1], 8'hC3);
    tx[0] = 8'hC4; tx[1] = 8'h00; xfer(2, 8);
    status_i = 8'h77;
    tx[0] = 8'h80; tx[1] = 8'h00; xfer(2, 8);
    check("R2 status back to zero", rx[0], 8'h00);
  endtask

  task automatic t_modes;
    tx[0] = 8'h20; tx[1] = 8'hC1; tx[2] = 8'h99; xfer(3, 8);
    check("R6 fbuf_rd", c_frd, 1);
    check("R8 no write after strobe", rg(1), 8'h00);
    tx[0] = 8'h60; tx[1] = 8'h20; xfer(2, 8);
    check("R6 fbuf_wr", c_fwr, 1);
    check("R8 later byte no strobe", c_frd, 1);
    tx[0] = 8'h1F; tx[1] = 8'h00; xfer(2, 8);
    check("R7 sram_rd", c_srd, 1);
    tx[0] = 8'h40; tx[1] = 8'h00; xfer(2, 8);
    check("R7 sram_wr", c_swr, 1);
    check("R8 totals", c_frd + c_fwr + c_srd + c_swr, 4);
  endtask

  task automatic t_abort;
    tx[0] = 8'hC7; tx[1] = 8'h5A; xfer(2, 5);
    check("R9 no partial write", rg(7), 8'h00);
    tx[0] = 8'h8A; xfer(1, 4);
    tx[0] = 8'h87; tx[1] = 8'h00; xfer(2, 8);
    check("R9 fresh command", rx[1], 8'h00);
    tx[0] = 8'hC7; tx[1] = 8'h5A; xfer(2, 8);
    check("R9 later write ok", rg(7), 8'h5A);
  endtask

  task automatic t_extra;
    tx[0] = 8'hC5; tx[1] = 8'h33; tx[2] = 8'h77; xfer(3, 8);
    check("R10 second byte stored", rg(5), 8'h33);
    tx[0] = 8'h85; tx[1] = 8'h00; tx[2] = 8'h00; xfer(3, 8);
    check("R10 third byte zero out", rx[2], 8'h00);
    check("R10 reg unchanged", rg(5), 8'h33);
  endtask

  initial begin
    wait_clk(3);
    t_reset;
    rst_n = 1'b1;
    wait_clk(4);
    t_write_read;
    t_status;
    t_modes;
    t_abort;
    t_extra;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule